// File: doc/BRIEF.md
# Double-Buffered DAC Input Register

This block is the digital front end of a 12-bit digital-to-analog converter. A first rank of three 4-bit holding registers collects a code one nibble at a time. A 12-bit second rank holds the code that actually drives the converter. The second rank takes the whole first rank in a single transfer, so the converter never sees a half-written code.

In direct mode, a 12-bit bus is steered by an active-low chip select and four active-low strobes. Three of the strobes open one nibble each, and the fourth triggers the transfer into the second rank. In byte mode, two writes from an 8-bit bus go to offsets 01 and 10. The block turns these into nibble enables for either a left-justified or a right-justified layout.

An output stage presents the held code as straight binary, offset binary or twos complement. All storage is clocked: a write takes effect on the rising clock edge where `wr_i` is high.

Top module: `dac_input_reg`

## Requirements
- R1: After `rst_ni` is asserted, both ranks hold 000h. A transfer-only write then yields `dac_code_o` = 000h.
- R2: A write with `cs_ni` high, or any cycle with `wr_i` low, changes neither rank.
- R3: In direct mode, a write with `cs_ni` low and all four `addr_ni` bits high changes neither rank.
- R4: In direct mode, `addr_ni[0]` low loads `data_i[3:0]` into first-rank bits 3:0. `addr_ni[1]` low loads `data_i[7:4]` into bits 7:4, and `addr_ni[2]` low loads `data_i[11:8]` into bits 11:8. Nibbles whose strobe is high keep their value.
- R5: In direct mode, `addr_ni[3]` low copies the first rank into the second rank in one cycle. First-rank writes alone leave `dac_code_o` unchanged.
- R6: When `addr_ni[3]` is low together with first-rank strobes, the second rank takes the incoming bus nibbles for those sections, never their old first-rank contents. With all four strobes low, `data_i` reaches `dac_code_o` in that single write.
- R7: In byte mode with `right_just_i`=0, offset 01 loads `data_i[7:4]` into code bits 3:0. Offset 10 loads `data_i[7:0]` into code bits 11:4 and updates the second rank in the same write.
- R8: In byte mode with `right_just_i`=1, offset 01 loads `data_i[7:0]` into code bits 7:0 without updating. Offset 10 loads `data_i[3:0]` into code bits 11:8 and updates the second rank.
- R9: In byte mode, writes to offsets 00 and 11 change neither rank, and `addr_ni` is ignored.
- R10: `code_mode_i` selects the output coding:
  - 00 gives straight binary and 01 gives offset binary; both pass the held code unchanged.
  - 10 gives twos complement, inverting bit 11.
  - 11 behaves as 00.
  - `bipolar_o` is 1 for modes 01 and 10 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe, sampled on the rising edge |
| cs_ni | input | 1 | Chip select, active low |
| addr_ni | input | 4 | Direct-mode strobes, active low: bits 0..2 nibble enables, bit 3 transfer |
| byte_mode_i | input | 1 | 1 selects two-write 8-bit bus mode |
| right_just_i | input | 1 | Byte mode layout: 0 left-justified, 1 right-justified |
| byte_addr_i | input | 2 | Byte mode offset |
| data_i | input | 12 | Write data; byte mode uses bits 7:0 |
| code_mode_i | input | 2 | Output coding select |
| dac_code_o | output | 12 | Code presented to the converter |
| bipolar_o | output | 1 | High for a bipolar coding |

## Verification
A first-rank nibble load and a second-rank transfer can land in the same write. This is the case where stale data could leak into the converter code. The bench sweeps all sixteen strobe combinations against changing bus patterns. After each write it issues a transfer-only write, which exposes the first rank separately from the second. Both results are compared with a bench-side model of the enable rules. Byte-mode offset 10 is the same overlap in wrapped form, and is judged by the assembled code right after that write.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
  typedef enum logic [1:0] {
    CODE_STRAIGHT = 2'b00,
    CODE_OFFSET   = 2'b01,
    CODE_TWOS     = 2'b10,
    CODE_ALT      = 2'b11
  } code_mode_e;

  localparam logic [1:0] OFF_LOW  = 2'b01;
  localparam logic [1:0] OFF_HIGH = 2'b10;
endpackage

// File: rtl/dacreg_byte_map.sv
module dacreg_byte_map import dacreg_pkg::*; #(
  parameter int NIB_W   = 4,
  parameter int NIBBLES = 3,
  localparam int CODE_W = NIB_W * NIBBLES,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              byte_mode_i,
  input  logic              right_just_i,
  input  logic [1:0]        byte_addr_i,
  input  logic [NIBBLES:0]  addr_ni,
  input  logic [CODE_W-1:0] data_i,
  output logic [NIBBLES:0]  en_o,
  output logic [CODE_W-1:0] bus_o
);
  always_comb begin
    en_o  = '0;
    bus_o = '0;
    if (!byte_mode_i) begin
      en_o  = ~addr_ni;
      bus_o = data_i;
    end else if (!right_just_i) begin
      if (byte_addr_i == OFF_LOW) begin
        bus_o[NIB_W-1:0] = data_i[BYTE_W-1:NIB_W];
        en_o[0] = 1'b1;
      end else if (byte_addr_i == OFF_HIGH) begin
        bus_o[CODE_W-1:CODE_W-BYTE_W] = data_i[BYTE_W-1:0];
        for (int k = NIBBLES - 2; k < NIBBLES; k++) en_o[k] = 1'b1;
        en_o[NIBBLES] = 1'b1;
      end
    end else begin
      if (byte_addr_i == OFF_LOW) begin
        bus_o[BYTE_W-1:0] = data_i[BYTE_W-1:0];
        for (int k = 0; k < 2; k++) en_o[k] = 1'b1;
      end else if (byte_addr_i == OFF_HIGH) begin
        bus_o[CODE_W-1:BYTE_W] = data_i[CODE_W-BYTE_W-1:0];
        for (int k = 2; k < NIBBLES; k++) en_o[k] = 1'b1;
        en_o[NIBBLES] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dacreg_ranks.sv
module dacreg_ranks #(
  parameter int NIB_W   = 4,
  parameter int NIBBLES = 3,
  localparam int CODE_W = NIB_W * NIBBLES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NIBBLES:0]  en_i,
  input  logic [CODE_W-1:0] bus_i,
  output logic [CODE_W-1:0] rank1_o,
  output logic [CODE_W-1:0] rank2_o
);
  logic load;
  assign load = en_i[NIBBLES];

  for (genvar k = 0; k < NIBBLES; k++) begin : g_nib
    localparam int LO = k * NIB_W;
    logic [NIB_W-1:0] fwd;
    // forward fresh bus nibble when both ranks open in one write
    assign fwd = en_i[k] ? bus_i[LO +: NIB_W] : rank1_o[LO +: NIB_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rank1_o[LO +: NIB_W] <= '0;
        rank2_o[LO +: NIB_W] <= '0;
      end else begin
        if (en_i[k]) rank1_o[LO +: NIB_W] <= bus_i[LO +: NIB_W];
        if (load)    rank2_o[LO +: NIB_W] <= fwd;
      end
    end

    assert_fwd_fresh_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load && en_i[k]) |=> (rank2_o[LO +: NIB_W] == $past(bus_i[LO +: NIB_W])));
    assert_nib_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[k] |=> $stable(rank1_o[LO +: NIB_W]));
  end

  assert_rank2_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(rank2_o));
endmodule

// File: rtl/dacreg_coder.sv
module dacreg_coder import dacreg_pkg::*; #(
  parameter int CODE_W = 12
) (
  input  logic [1:0]        mode_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o,
  output logic              bipolar_o
);
  always_comb begin
    code_o    = code_i;
    bipolar_o = 1'b0;
    case (code_mode_e'(mode_i))
      CODE_OFFSET: bipolar_o = 1'b1;
      CODE_TWOS: begin
        code_o[CODE_W-1] = ~code_i[CODE_W-1];
        bipolar_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dac_input_reg.sv
module dac_input_reg import dacreg_pkg::*; #(
  parameter int NIB_W   = 4,
  parameter int NIBBLES = 3,
  localparam int CODE_W = NIB_W * NIBBLES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              cs_ni,
  input  logic [NIBBLES:0]  addr_ni,
  input  logic              byte_mode_i,
  input  logic              right_just_i,
  input  logic [1:0]        byte_addr_i,
  input  logic [CODE_W-1:0] data_i,
  input  logic [1:0]        code_mode_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              bipolar_o
);
  logic [NIBBLES:0]  en_raw, en;
  logic [CODE_W-1:0] bus, rank1, rank2;

  dacreg_byte_map #(.NIB_W(NIB_W), .NIBBLES(NIBBLES)) u_map (
    .byte_mode_i (byte_mode_i),
    .right_just_i(right_just_i),
    .byte_addr_i (byte_addr_i),
    .addr_ni     (addr_ni),
    .data_i      (data_i),
    .en_o        (en_raw),
    .bus_o       (bus)
  );

  assign en = (wr_i && !cs_ni) ? en_raw : '0;

  dacreg_ranks #(.NIB_W(NIB_W), .NIBBLES(NIBBLES)) u_ranks (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .bus_i  (bus),
    .rank1_o(rank1),
    .rank2_o(rank2)
  );

  dacreg_coder #(.CODE_W(CODE_W)) u_coder (
    .mode_i   (code_mode_i),
    .code_i   (rank2),
    .code_o   (dac_code_o),
    .bipolar_o(bipolar_o)
  );

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || !wr_i) |=> ($stable(rank1) && $stable(rank2)));
  assert_noaddr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && wr_i && !byte_mode_i && (&addr_ni)) |=> ($stable(rank1) && $stable(rank2)));
  assert_badoff_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_mode_i && (byte_addr_i == 2'b00 || byte_addr_i == 2'b11))
      |=> ($stable(rank1) && $stable(rank2)));
  assert_twos_msb_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_mode_i == CODE_TWOS) |-> (dac_code_o[CODE_W-1] != rank2[CODE_W-1]));
endmodule

// File: tb/sim_dac_input_reg.sv
module sim_dac_input_reg;
  logic        clk = 0, rst_ni = 0, wr = 0, cs_n = 1;
  logic [3:0]  addr_n = 4'hF;
  logic        bm = 0, rj = 0;
  logic [1:0]  boff = 0, cmode = 0;
  logic [11:0] data = 0, dout;
  logic        bip;
  int checks = 0, fails = 0;
  logic [11:0] m1 = 0, m2 = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dac_input_reg u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr), .cs_ni(cs_n), .addr_ni(addr_n),
    .byte_mode_i(bm), .right_just_i(rj), .byte_addr_i(boff), .data_i(data),
    .code_mode_i(cmode), .dac_code_o(dout), .bipolar_o(bip)
  );

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %03h expected %03h", req, act, exp);
    end
  endtask

  task automatic wcyc(logic c, logic w, logic [3:0] a, logic [1:0] o, logic [11:0] d);
    @(negedge clk);
    cs_n = c; wr = w; addr_n = a; boff = o; data = d;
    @(negedge clk);
    wr = 0; cs_n = 1; addr_n = 4'hF;
  endtask

  // direct-mode model from R4/R5/R6
  function automatic void model(logic [3:0] a, logic [11:0] d);
    logic [3:0] e = ~a;
    logic [11:0] n1 = m1;
    for (int k = 0; k < 3; k++) if (e[k]) n1[k*4 +: 4] = d[k*4 +: 4];
    if (e[3]) m2 = n1;
    m1 = n1;
  endfunction

  task automatic peek_r1(string req);
    wcyc(0, 1, 4'b0111, 2'b00, 12'h000);
    m2 = m1;
    chk(req, dout, m1);
  endtask

  function automatic logic [11:0] pat(int i, int j);
    logic [11:0] p = 12'(i * 12'h1D3 + j * 12'h2A7 + 12'h5C1);
    return p;
  endfunction

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog: got 0 expected 1");
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1
    chk("R1", dout, 12'h000);
    peek_r1("R1");

    // direct sweep: every strobe row
    for (int j = 0; j < 4; j++) begin
      for (int a = 0; a < 16; a++) begin
        logic [11:0] d = pat(a, j);
        string tag;
        if (a == 15) tag = "R3";
        else if (a == 0) tag = "R6";
        else if (!a[3] && (a[2:0] != 3'b111)) tag = "R6";
        else if (!a[3]) tag = "R5";
        else tag = "R4";
        wcyc(0, 1, 4'(a), 2'b00, d);
        model(4'(a), d);
        chk(tag, dout, m2);
        peek_r1(tag);
      end
    end

    // R2: chip select high / write strobe low
    for (int j = 0; j < 4; j++) begin
      wcyc(1, 1, 4'b0000, 2'b00, ~pat(j, 7));
      chk("R2", dout, m2);
      wcyc(0, 0, 4'b0000, 2'b00, ~pat(j, 9));
      chk("R2", dout, m2);
      peek_r1("R2");
    end

    // byte mode
    bm = 1;
    for (int r = 0; r < 2; r++) begin
      rj = 1'(r);
      for (int j = 0; j < 6; j++) begin
        logic [7:0] b1 = 8'(pat(j, r) >> 2);
        logic [7:0] b2 = 8'(pat(r, j) >> 1);
        logic [11:0] exp;
        string tag = (r == 0) ? "R7" : "R8";
        exp = (r == 0) ? {b2, b1[7:4]} : {b2[3:0], b1};
        wcyc(0, 1, 4'b0000, 2'b01, {4'hF, b1});
        chk(tag, dout, m2);
        wcyc(0, 1, 4'b0000, 2'b10, {4'hF, b2});
        m1 = (r == 0) ? exp : {b2[3:0], b1};
        m2 = exp;
        chk(tag, dout, exp);
        wcyc(0, 1, 4'b0000, 2'b00, 12'hFFF);
        chk("R9", dout, m2);
        wcyc(0, 1, 4'b0000, 2'b11, 12'h5A5);
        chk("R9", dout, m2);
        bm = 0;
        peek_r1("R9");
        bm = 1;
      end
    end
    bm = 0;

    // R10 coding sweep
    for (int m = 0; m < 4; m++) begin
      cmode = 2'(m);
      for (int c = 0; c < 4096; c++) begin
        wcyc(0, 1, 4'b0000, 2'b00, 12'(c));
        chk("R10", dout, (m == 2) ? (12'(c) ^ 12'h800) : 12'(c));
        chk("R10", {11'd0, bip}, {11'd0, (m == 1 || m == 2)});
      end
    end

    // reset again mid-run
    rst_ni = 0;
    @(negedge clk);
    rst_ni = 1;
    cmode = 0;
    m1 = 0; m2 = 0;
    chk("R1", dout, 12'h000);
    peek_r1("R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule